// File: doc/BRIEF.md
# Parallel-Chain Scan Self-Test Sequencer

This block runs a test-per-scan self-test on its own. One shared LFSR produces a pseudo-random bit stream. A small XOR network spreads that stream across a set of parallel scan chains so that neighbouring chains receive decorrelated data rather than delayed copies of one sequence. Every pattern is shifted into all chains at once, over as many clocks as a chain is long. The block then switches to functional mode for exactly one capture clock, in which a simple stand-in function plays the role of the logic under test. The captured values are shifted out into a multiple-input signature register (MISR) while the next pattern is shifted in.

The MISR takes one input from the output end of each chain, so its width equals the chain count rather than the number of captured bits. A pattern count taken at start sets the length of the test. When the last pattern has been unloaded, the block raises `done` and holds the signature. A fault-injection input can flip one captured bit, so that the effect of a defect on the signature can be observed.

Top module: `stumps_bist`

## Requirements
- R1: After reset, `done` is 0 and `signature` is all zeros.
- R2: A start loads the LFSR from `seed`, or with 1 when `seed` is zero. In every shift cycle the LFSR steps as a right-shifting Galois register: s' = (s >> 1) ^ (s[0] ? TAPS : 0), with TAPS = 16'hB400 by default. It does not step in capture cycles.
- R3: In a shift cycle, chain i receives s[i mod W] ^ s[(2i+1) mod W] ^ s[(5i+3) mod W], where s is the LFSR state before it steps and W is the LFSR width.
- R4: Each shift cycle moves every chain one place toward its output. The new bit enters at bit 0 and bit LEN-1 is the scan-out bit, so loading a pattern takes LEN cycles.
- R5: A capture takes exactly one cycle. In that cycle bit j of chain i becomes c[i][j] ^ (c[(i+1) mod N][j] & c[i][(j+1) mod LEN]). When `inj_en` is high in that cycle, bit 0 of chain `inj_chain` is also inverted.
- R6: The MISR is N bits wide, with bit i taking the scan-out of chain i. On each unload shift it updates as m' = (m << 1) ^ (m[N-1] ? POLY : 0) ^ so, with POLY = 25'h9 by default. It is cleared at start and holds while the first pattern loads.
- R7: The unload of pattern k uses the same LEN shift cycles as the load of pattern k+1, so a run of P patterns takes LEN + P·(LEN+1) cycles after the start edge.
- R8: `done` rises exactly LEN + P·(LEN+1) rising edges after the edge that samples `start`, where P is the `pat_count` value taken at start.
- R9: A start with `pat_count` equal to 0 raises `done` at the next edge with a signature of zero.
- R10: While a run is in progress, `start`, `seed` and `pat_count` are ignored. Once `done` is high, it and `signature` stay unchanged until the next start.
- R11: With the same seed and a one-pattern run, injecting a flipped captured bit gives a signature different from the fault-free one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when the block is not busy |
| seed | input | 16 | LFSR starting value |
| pat_count | input | 16 | Number of patterns in the run |
| inj_en | input | 1 | Inverts a captured bit during capture |
| inj_chain | input | 5 | Chain whose bit 0 is inverted |
| done | output | 1 | Run finished, signature valid |
| signature | output | 25 | MISR contents |

## Verification
The hardest situation to reach from the ports is one where the signature differs only because of what happened inside a single capture cycle. Every other bit the MISR receives is buried under hundreds of pseudo-random shifts. To reach it, the stimulus reruns the same seed with a single pattern, once clean and once with the injected flip. The bench's own model of the chains predicts both signatures. Other runs pulse `start` and change `seed` and `pat_count` part-way through, and also cover a zero seed and a zero pattern count.

// File: rtl/stumps_bist.sv
module stumps_bist #(
  parameter int N_CHAINS  = 25,
  parameter int CHAIN_LEN = 40,
  parameter int LFSR_W    = 16,
  parameter int PAT_W     = 16,
  parameter logic [LFSR_W-1:0]   LFSR_TAPS = 16'hB400,
  parameter logic [N_CHAINS-1:0] MISR_POLY = 25'h0000009
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [LFSR_W-1:0]           seed,
  input  logic [PAT_W-1:0]            pat_count,
  input  logic                        inj_en,
  input  logic [$clog2(N_CHAINS)-1:0] inj_chain,
  output logic                        done,
  output logic [N_CHAINS-1:0]         signature
);
  localparam int CW = $clog2(N_CHAINS);
  localparam int BW = $clog2(CHAIN_LEN);
  localparam logic [BW-1:0] LAST_BIT = BW'(CHAIN_LEN - 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_CAP, S_DONE} state_t;

  state_t                state;
  logic [LFSR_W-1:0]     lfsr;
  logic [N_CHAINS-1:0]   misr;
  logic [BW-1:0]         bitcnt;
  logic [PAT_W-1:0]      left;
  logic                  unload;
  logic [CHAIN_LEN-1:0]  chain   [N_CHAINS];
  logic [CHAIN_LEN-1:0]  cap_nxt [N_CHAINS];
  logic [N_CHAINS-1:0]   si, so;

  wire busy = (state == S_SHIFT) || (state == S_CAP);
  wire [LFSR_W-1:0]   lfsr_nxt = (lfsr >> 1) ^ (lfsr[0] ? LFSR_TAPS : '0);
  wire [N_CHAINS-1:0] misr_nxt = {misr[N_CHAINS-2:0], 1'b0}
                                 ^ (misr[N_CHAINS-1] ? MISR_POLY : '0) ^ so;

  for (genvar i = 0; i < N_CHAINS; i++) begin : g_chain
    localparam int TA = i % LFSR_W;
    localparam int TB = (2 * i + 1) % LFSR_W;
    localparam int TC = (5 * i + 3) % LFSR_W;
    localparam int NB = (i + 1) % N_CHAINS;
    assign si[i] = lfsr[TA] ^ lfsr[TB] ^ lfsr[TC];
    assign so[i] = chain[i][CHAIN_LEN-1];
    for (genvar j = 0; j < CHAIN_LEN; j++) begin : g_bit
      localparam int JN = (j + 1) % CHAIN_LEN;
      if (j == 0) begin : g_inj
        assign cap_nxt[i][j] = chain[i][j] ^ (chain[NB][j] & chain[i][JN])
                               ^ (inj_en && inj_chain == CW'(i));
      end else begin : g_plain
        assign cap_nxt[i][j] = chain[i][j] ^ (chain[NB][j] & chain[i][JN]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      lfsr   <= '0;
      misr   <= '0;
      bitcnt <= '0;
      left   <= '0;
      unload <= 1'b0;
      for (int i = 0; i < N_CHAINS; i++) chain[i] <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE: if (start) begin
          lfsr   <= (seed == '0) ? LFSR_W'(1) : seed;
          misr   <= '0;
          bitcnt <= '0;
          left   <= pat_count;
          unload <= 1'b0;
          state  <= (pat_count == '0) ? S_DONE : S_SHIFT;
        end
        S_SHIFT: begin
          lfsr <= lfsr_nxt;
          for (int i = 0; i < N_CHAINS; i++)
            chain[i] <= {chain[i][CHAIN_LEN-2:0], si[i]};
          if (unload) misr <= misr_nxt;
          if (bitcnt == LAST_BIT) begin
            bitcnt <= '0;
            state  <= (left == '0) ? S_DONE : S_CAP;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
        S_CAP: begin
          for (int i = 0; i < N_CHAINS; i++) chain[i] <= cap_nxt[i];
          left   <= left - 1'b1;
          unload <= 1'b1;
          state  <= S_SHIFT;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign done      = (state == S_DONE);
  assign signature = misr;

  AST_RESET_CLEAN: assert property (@(posedge clk)
    $past(!rst_n) |-> !done && signature == '0); // R1
  AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= LAST_BIT); // R4
  AST_CAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_CAP |=> state == S_SHIFT); // R5
  AST_MISR_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_SHIFT && !unload |=> $stable(signature)); // R6
  AST_DONE_FROM_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) && $past(busy) |-> $past(state == S_SHIFT && bitcnt == LAST_BIT)); // R8
  AST_ZERO_PATS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && pat_count == '0 |=> done && signature == '0); // R9
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(signature)); // R10
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_SHIFT && bitcnt != LAST_BIT |=> state == S_SHIFT && !done); // R10
endmodule

// File: tb/stumps_bist_test.sv
module stumps_bist_test;
  localparam int N = 25, L = 40, W = 16;
  localparam logic [W-1:0] TAPS = 16'hB400;
  localparam logic [N-1:0] POLY = 25'h0000009;

  logic clk = 0, rst_n = 0, start = 0, inj_en = 0;
  logic [W-1:0] seed = '0;
  logic [15:0]  pat_count = '0;
  logic [4:0]   inj_chain = '0;
  logic done;
  logic [N-1:0] signature;
  int n_chk = 0, n_bad = 0;
  logic [N-1:0] sig_clean, sig_flip;

  stumps_bist uut (.clk(clk), .rst_n(rst_n), .start(start), .seed(seed),
    .pat_count(pat_count), .inj_en(inj_en), .inj_chain(inj_chain),
    .done(done), .signature(signature));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] model(input logic [W-1:0] sd, input int p, input bit ij, input int ic);
    logic [W-1:0] s;
    logic [N-1:0] m, so;
    logic [L-1:0] c [N];
    logic [L-1:0] nc [N];
    s = (sd == 0) ? W'(1) : sd;
    m = '0;
    for (int i = 0; i < N; i++) c[i] = '0;
    if (p == 0) return '0;
    for (int k = 0; k <= p; k++) begin
      for (int t = 0; t < L; t++) begin
        for (int i = 0; i < N; i++) so[i] = c[i][L-1];
        if (k > 0) m = {m[N-2:0], 1'b0} ^ (m[N-1] ? POLY : '0) ^ so;
        for (int i = 0; i < N; i++)
          c[i] = {c[i][L-2:0], s[i % W] ^ s[(2*i+1) % W] ^ s[(5*i+3) % W]};
        s = (s >> 1) ^ (s[0] ? TAPS : '0);
      end
      if (k < p) begin
        for (int i = 0; i < N; i++)
          for (int j = 0; j < L; j++)
            nc[i][j] = c[i][j] ^ (c[(i+1) % N][j] & c[i][(j+1) % L]);
        if (ij && ic < N) nc[ic][0] = ~nc[ic][0];
        for (int i = 0; i < N; i++) c[i] = nc[i];
      end
    end
    return m;
  endfunction

  task automatic run(input logic [W-1:0] sd, input int p, input bit ij, input int ic,
                     input bit poke, input string req, output logic [N-1:0] got);
    logic [N-1:0] exp;
    int t;
    exp = model(sd, p, ij, ic);
    t = L + p * (L + 1);
    @(negedge clk);
    seed = sd; pat_count = 16'(p); inj_en = ij; inj_chain = 5'(ic); start = 1;
    @(negedge clk);
    start = 0;
    if (p > 0) begin
      for (int c = 1; c < t; c++) begin
        if (poke && c == 3) begin start = 1; seed = W'($urandom); pat_count = 16'($urandom_range(1, 9)); end
        if (poke && c == 4) start = 0;
        @(negedge clk);
      end
      chk(done == 1'b0, "R8 done early", 64'(done), 64'd0);
      @(negedge clk);
    end
    chk(done == 1'b1, "R8 done on time", 64'(done), 64'd1);
    chk(signature == exp, req, 64'(signature), 64'(exp));
    got = signature;
    repeat (5) @(negedge clk);
    chk(done && signature == exp, "R10 hold after done", 64'(signature), 64'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [N-1:0] g;
    void'($urandom(7));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(done == 1'b0, "R1 done after reset", 64'(done), 64'd0);
    chk(signature == '0, "R1 signature after reset", 64'(signature), 64'd0);

    run(16'hACE1, 1, 0, 0, 0, "R11 clean signature", sig_clean);
    run(16'hACE1, 1, 1, 7, 0, "R5 injected signature", sig_flip);
    chk(sig_clean != sig_flip, "R11 flip changes signature", 64'(sig_flip), 64'(sig_clean));
    run(16'h0000, 2, 0, 0, 0, "R2 zero seed signature", g);
    run(16'h0001, 2, 0, 0, 0, "R2 seed one matches zero seed", sig_clean);
    chk(g == sig_clean, "R2 zero seed acts as one", 64'(g), 64'(sig_clean));
    run(16'h1234, 0, 0, 0, 0, "R9 zero patterns", g);
    run(16'h5A5A, 3, 0, 0, 1, "R10 mid-run start ignored", g);
    run(16'hFFFF, 1, 1, 24, 0, "R5 inject last chain", g);
    run(16'h0F0F, 2, 1, 30, 0, "R5 out-of-range chain no effect", g);
    for (int r = 0; r < 6; r++)
      run(W'($urandom), $urandom_range(1, 6), 1'($urandom), $urandom_range(0, N-1), 0,
          "R3 R4 R6 R7 random run", g);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule